// File: doc/BRIEF.md
# Constant-Coefficient Multiplier with Pre-Encoded Radix-4 Signed Digits

This block multiplies a two's-complement data operand by one entry of a fixed table of constant coefficients, such as the taps of a filter bank or the twiddle factors of a transform. Each coefficient is converted to radix-4 signed digits while the design is elaborated, and only the digit codes are kept in an internal table. The datapath therefore holds no coefficient recoder. It forms one partial product per digit and sums the partial products into the full-width signed product.

All digits except the top one use a non-redundant set of four values, so each needs only 2 bits. A parameter picks one of two sets: the low set {-2,-1,0,+1} or the high set {-1,0,+1,+2}. The most significant digit uses the five-value radix-4 Booth set in 3 bits, so every two's-complement coefficient can be represented, including the most negative one. A packed coefficient takes N+1 bits. The caller strobes `in_valid` with an index and an operand, and one cycle later `out_valid` marks the registered product.

Top module: `presd_mult`

## Requirements
- R1: When `in_valid` is high on a rising edge, `out_product` at the next edge equals the exact signed 2N-bit product of `in_data` and coefficient `in_coef_idx`.
- R2: Coefficient k is: k=0 the most negative N-bit value; k=1 all ones (-1); k=2 the largest positive value; k=3 zero; k=4 one; any other k the low N bits of the 32-bit wrapped product k*2654435761, read as signed.
- R3: `out_valid` is high exactly on the cycle after a cycle with `in_valid` high, and low otherwise.
- R4: While `in_valid` is low, `out_product` keeps its previous value.
- R5: While reset is held, and after its release until the first accepted operand, `out_valid` is 0 and `out_product` is 0.
- R6: With HI_SET=0, each low digit uses codes 00=0, 01=+1, 10=-1, 11=-2.
- R7: With HI_SET=1, each low digit uses codes 00=0, 01=-1, 10=+1, 11=+2.
- R8: The top digit is stored as a 3-bit code {negate, double, single} taking only 000, 001, 010, 101 or 110, and the packed word is N+1 bits: N/2-1 two-bit low digits followed by the top code.
- R9: The most negative coefficient times the most negative operand gives +2^(2N-2) without overflow in either digit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| in_coef_idx | input | IDX_W | Coefficient table index |
| in_data | input | N | Signed data operand |
| out_valid | output | 1 | Product valid strobe |
| out_product | output | 2N | Signed product |

## Verification
Every product is due one rising edge after its operand is strobed, so the bench drives operands on falling edges and samples results on the following falling edge. The driver pushes the expected product into a queue when it strobes an operand. The monitor pops one entry on every falling edge where `out_valid` is high, and on all other falling edges it checks that the output has not changed. Both digit sets are driven with the same stimulus and compared against the same queue entry, so the result from each digit set is checked against the same known value in the same cycle.

// File: rtl/presd_pkg.sv
package presd_pkg;

  // Top-digit code fields {negate, double, single}
  localparam logic [2:0] TOP_ZERO = 3'b000;
  localparam logic [2:0] TOP_P1   = 3'b001;
  localparam logic [2:0] TOP_P2   = 3'b010;
  localparam logic [2:0] TOP_M1   = 3'b101;
  localparam logic [2:0] TOP_M2   = 3'b110;

  // Coefficient table contents; low n bits are meaningful
  function automatic logic [63:0] coef_value(input int k, input int n);
    logic [31:0] h;
    logic [63:0] mask;
    mask = (64'd1 << n) - 64'd1;
    h    = 32'(k) * 32'd2654435761;
    case (k)
      0:       return 64'd1 << (n - 1);
      1:       return mask;
      2:       return (64'd1 << (n - 1)) - 64'd1;
      3:       return 64'd0;
      4:       return 64'd1;
      default: return {32'd0, h} & mask;
    endcase
  endfunction

  // Recode an n-bit two's-complement value into packed signed digits
  function automatic logic [63:0] encode_coef(input logic [63:0] b, input int n,
                                              input bit hi_set);
    logic [63:0] w;
    int          c;
    int          v;
    w = '0;
    c = 0;
    for (int i = 0; i < n / 2 - 1; i++) begin
      v = 2 * int'(b[2*i+1]) + int'(b[2*i]) + c;
      if (hi_set) begin
        case (v)
          0:       begin w[2*i +: 2] = 2'b00; c = 0; end
          1:       begin w[2*i +: 2] = 2'b10; c = 0; end
          2:       begin w[2*i +: 2] = 2'b11; c = 0; end
          3:       begin w[2*i +: 2] = 2'b01; c = 1; end
          default: begin w[2*i +: 2] = 2'b00; c = 1; end
        endcase
      end else begin
        case (v)
          0:       begin w[2*i +: 2] = 2'b00; c = 0; end
          1:       begin w[2*i +: 2] = 2'b01; c = 0; end
          2:       begin w[2*i +: 2] = 2'b11; c = 1; end
          3:       begin w[2*i +: 2] = 2'b10; c = 1; end
          default: begin w[2*i +: 2] = 2'b00; c = 1; end
        endcase
      end
    end
    v = -2 * int'(b[n-1]) + int'(b[n-2]) + c;
    case (v)
      -2:      w[n-2 +: 3] = TOP_M2;
      -1:      w[n-2 +: 3] = TOP_M1;
      1:       w[n-2 +: 3] = TOP_P1;
      2:       w[n-2 +: 3] = TOP_P2;
      default: w[n-2 +: 3] = TOP_ZERO;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/presd_coef_rom.sv
module presd_coef_rom #(
  parameter int N      = 16,
  parameter int IDX_W  = 4,
  parameter bit HI_SET = 1'b0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [N:0]       word
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int WW    = N + 1;

  logic [DEPTH-1:0][WW-1:0] table_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam logic [63:0] ENC =
      presd_pkg::encode_coef(presd_pkg::coef_value(k, N), N, HI_SET);
    assign table_q[k] = ENC[WW-1:0];
  end

  assign word = table_q[idx];
endmodule

// File: rtl/presd_ppgen.sv
module presd_ppgen #(
  parameter int N      = 16,
  parameter bit IS_TOP = 1'b0,
  parameter bit HI_SET = 1'b0,
  parameter int CW     = IS_TOP ? 3 : 2
) (
  input  logic [CW-1:0]  code,
  input  logic [N-1:0]   opa,
  output logic [2*N-1:0] row,
  output logic           neg
);
  localparam int PW = 2 * N;

  logic          sel1;
  logic          sel2;
  logic [N:0]    mag;
  logic [PW-1:0] ext;

  if (IS_TOP) begin : g_top
    always_comb begin
      neg  = code[CW-1];
      sel2 = code[1];
      sel1 = code[0];
    end
  end else begin : g_low
    always_comb begin
      sel1 = code[1] ^ code[0];
      sel2 = code[1] & code[0];
      if (code == 2'b00)      neg = 1'b0;
      else if (code == 2'b01) neg = HI_SET;
      else                    neg = ~HI_SET;
    end
  end

  always_comb begin
    if (sel2)      mag = {opa, 1'b0};
    else if (sel1) mag = {opa[N-1], opa};
    else           mag = '0;
    ext = {{(N-1){mag[N]}}, mag};
    row = neg ? ~ext : ext;
  end
endmodule

// File: rtl/presd_sum.sv
module presd_sum #(
  parameter int N  = 16,
  parameter int ND = N / 2
) (
  input  logic [ND-1:0][2*N-1:0] rows,
  input  logic [ND-1:0]          negs,
  output logic [2*N-1:0]         total
);
  localparam int PW = 2 * N;

  always_comb begin
    total = '0;
    for (int i = 0; i < ND; i++) begin
      total = total + (rows[i] << (2 * i)) + (PW'(negs[i]) << (2 * i));
    end
  end
endmodule

// File: rtl/presd_mult.sv
module presd_mult #(
  parameter int N      = 16,
  parameter int IDX_W  = 4,
  parameter bit HI_SET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_coef_idx,
  input  logic [N-1:0]     in_data,
  output logic             out_valid,
  output logic [2*N-1:0]   out_product
);
  localparam int ND = N / 2;
  localparam int PW = 2 * N;

  logic [1:0]            rst_sync;
  logic                  rst_q;
  logic [N:0]            rom_word;
  logic [ND-1:0][PW-1:0] rows;
  logic [ND-1:0]         negs;
  logic [PW-1:0]         sum;
  logic                  valid_d;
  logic [PW-1:0]         prod_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  presd_coef_rom #(.N(N), .IDX_W(IDX_W), .HI_SET(HI_SET)) u_rom (
    .idx  (in_coef_idx),
    .word (rom_word)
  );

  for (genvar i = 0; i < ND; i++) begin : g_pp
    if (i == ND - 1) begin : g_msd
      presd_ppgen #(.N(N), .IS_TOP(1'b1), .HI_SET(HI_SET)) u_pp (
        .code (rom_word[2*i +: 3]),
        .opa  (in_data),
        .row  (rows[i]),
        .neg  (negs[i])
      );
    end else begin : g_lsd
      presd_ppgen #(.N(N), .IS_TOP(1'b0), .HI_SET(HI_SET)) u_pp (
        .code (rom_word[2*i +: 2]),
        .opa  (in_data),
        .row  (rows[i]),
        .neg  (negs[i])
      );
    end
  end

  presd_sum #(.N(N), .ND(ND)) u_sum (
    .rows  (rows),
    .negs  (negs),
    .total (sum)
  );

  always_comb begin
    valid_d = in_valid;
    prod_d  = in_valid ? sum : out_product;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else begin
      out_valid   <= valid_d;
      out_product <= prod_d;
    end
  end
endmodule

// File: rtl/presd_mult_chk.sv
module presd_mult_chk #(
  parameter int N      = 16,
  parameter int IDX_W  = 4
) (
  input logic             clk,
  input logic             rst_q,
  input logic             in_valid,
  input logic [IDX_W-1:0] in_coef_idx,
  input logic [N-1:0]     in_data,
  input logic             out_valid,
  input logic [2*N-1:0]   out_product,
  input logic [N:0]       rom_word
);
  localparam int PW = 2 * N;

  logic [63:0]          cv;
  logic signed [PW-1:0] ref_prod;
  logic [2:0]           msd;

  always_comb begin
    cv       = presd_pkg::coef_value(int'(in_coef_idx), N);
    ref_prod = $signed({{N{in_data[N-1]}}, in_data}) *
               $signed({{N{cv[N-1]}}, cv[N-1:0]});
    msd      = rom_word[N:N-2];
  end

  // R1: registered product matches a plain signed multiply
  a_r1_product: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_product == $past(ref_prod));

  // R3: strobe follows input strobe by one cycle
  a_r3_valid_rise: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  a_r3_valid_low: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);

  // R4: product held while idle
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(out_product));

  // R8: top digit code is one of the five legal Booth codes
  a_r8_msd_code: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(msd[1:0]) && (msd[2] -> (msd[1] | msd[0])));
endmodule

bind presd_mult presd_mult_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .in_valid    (in_valid),
  .in_coef_idx (in_coef_idx),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_product (out_product),
  .rom_word    (rom_word)
);

// File: tb/presd_mult_test.sv
module presd_mult_test;
  localparam int N     = 16;
  localparam int IDX_W = 4;
  localparam int PW    = 2 * N;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [IDX_W-1:0] in_coef_idx;
  logic [N-1:0]     in_data;
  logic             lo_valid, hi_valid;
  logic [PW-1:0]    lo_prod, hi_prod;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [PW-1:0] exp_q[$];
  logic [PW-1:0] last_prod;

  // R6: low digit set
  presd_mult #(.N(N), .IDX_W(IDX_W), .HI_SET(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef_idx(in_coef_idx),
    .in_data(in_data), .out_valid(lo_valid), .out_product(lo_prod));

  // R7: high digit set
  presd_mult #(.N(N), .IDX_W(IDX_W), .HI_SET(1'b1)) uut_hi (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef_idx(in_coef_idx),
    .in_data(in_data), .out_valid(hi_valid), .out_product(hi_prod));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R2 coefficient model, written from the requirement
  function automatic longint model_coef(input int k);
    logic [31:0] h;
    logic [N-1:0] c;
    h = 32'(k) * 32'd2654435761;
    case (k)
      0:       c = {1'b1, {(N-1){1'b0}}};
      1:       c = '1;
      2:       c = {1'b0, {(N-1){1'b1}}};
      3:       c = '0;
      4:       c = N'(1);
      default: c = h[N-1:0];
    endcase
    return longint'($signed(c));
  endfunction

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(input int k, input logic [N-1:0] d);
    longint a;
    a = longint'($signed(d));
    @(negedge clk);
    in_valid    = 1'b1;
    in_coef_idx = IDX_W'(k);
    in_data     = d;
    exp_q.push_back(PW'(a * model_coef(k)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom();
    end
  endtask

  // Monitor: result due one edge after the strobe, sampled on the next falling edge
  initial begin
    logic [PW-1:0] e;
    last_prod = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (lo_valid || hi_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected strobe", lo_prod, '0);
          end else begin
            e = exp_q.pop_front();
            check(lo_valid && hi_valid, "R3 strobe", {31'd0, lo_valid}, 1);
            check(lo_prod == e, "R1/R6 low set", lo_prod, e);
            check(hi_prod == e, "R1/R7 high set", hi_prod, e);
            last_prod = e;
          end
        end else begin
          check(lo_prod == last_prod && hi_prod == last_prod, "R4 hold",
                lo_prod, last_prod);
        end
      end
    end
  end

  initial begin
    logic [N-1:0] ext[5];
    ext[0] = {1'b1, {(N-1){1'b0}}};
    ext[1] = '1;
    ext[2] = {1'b0, {(N-1){1'b1}}};
    ext[3] = '0;
    ext[4] = N'(1);
    rst_n = 1'b0; in_valid = 1'b0; in_coef_idx = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!lo_valid && !hi_valid && lo_prod == 0 && hi_prod == 0, "R5 reset",
          lo_prod, '0);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    check(!lo_valid && lo_prod == 0, "R5 after release", lo_prod, '0);
    // R9 and R8: extreme coefficients with extreme operands
    drive(0, ext[0]);
    idle(1);
    for (int k = 0; k < DEPTH; k++)
      for (int j = 0; j < 5; j++) drive(k, ext[j]);
    idle(3);
    // R1/R2: random back-to-back stream
    for (int i = 0; i < 300; i++) drive($urandom_range(DEPTH - 1), N'($urandom()));
    // R3/R4: stream with gaps
    for (int i = 0; i < 60; i++) begin
      drive($urandom_range(DEPTH - 1), N'($urandom()));
      idle($urandom_range(3));
    end
    idle(4);
    check(exp_q.size() == 0, "R3 all results seen", PW'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule